// File: doc/BRIEF.md
# Two-Port Hardware Semaphore Bank

This block holds a small set of token flags that two agents, a left port and a right port, use to claim shared resources without racing each other. It sits in an address space of its own, apart from any data memory. A port claims a flag by writing a 0 to it, then reads the flag back to learn whether the claim succeeded. It gives the flag up by writing a 1.

Each flag keeps two request flip-flops, one per side, and an ownership register. A port's write only sets or clears that port's own request. Ownership follows from the requests. An owner keeps the flag for as long as its request stands. A free flag goes to whichever side is requesting, and the left side wins when both request in the same cycle. When the owner releases, a request still pending on the other side takes the flag over at once.

Reads are combinational from the current state. The two sides see complementary views of an owned flag, and the same view of a free one.

Top module: `sem_bank`

## Requirements
- R1: The flag index is taken from address bits [2:0] of the port. All higher address bits have no effect on reads or writes.
- R2: On a write, only data bit 0 is used. Bit 0 = 0 is a request and bit 0 = 1 is a release. Data bits [7:1] have no effect.
- R3: When a side writes 0 to a free flag, that flag reads 0x00 on the writing side and 0xFF on the other side from the next clock cycle on.
- R4: While a flag is owned, writes from the non-owning side do not change what either side reads for that flag. This holds for a 0-write and for a 1-write.
- R5: When the owner writes 1 and the other side has no pending request, the flag becomes free and reads 0xFF on both sides. When the other side does have a pending request, the other side becomes owner in the next cycle.
- R6: When both sides write 0 to the same free flag in the same cycle, the left side becomes owner. The right side's request stays pending and is granted when the left side releases.
- R7: While a port's select is high, its read data shows the indexed flag's status on all eight bits: 0x00 when that side owns the flag, 0xFF otherwise. While select is low, the read data is 0x00.
- R8: A rejected 0-write stays pending until the same side writes 1 to that flag. Once cancelled, the request is never granted.
- R9: After reset every flag is free and no request is pending, so every flag reads 0xFF on both sides.
- R10: A write takes effect only when both select and write are high. With select low, or with write low, the flags do not change.
- R11: The flags are independent. Traffic on one flag never changes another flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| lf_sel | input | 1 | Left port semaphore select |
| lf_wr | input | 1 | Left port write strobe (1 = write, 0 = read) |
| lf_addr | input | 15 | Left port address; bits [2:0] pick the flag |
| lf_wdata | input | 8 | Left port write data; bit 0 used |
| lf_rdata | output | 8 | Left port read data (status replicated) |
| rt_sel | input | 1 | Right port semaphore select |
| rt_wr | input | 1 | Right port write strobe (1 = write, 0 = read) |
| rt_addr | input | 15 | Right port address; bits [2:0] pick the flag |
| rt_wdata | input | 8 | Right port write data; bit 0 used |
| rt_rdata | output | 8 | Right port read data (status replicated) |

## Verification
Directed sequences come first. They cover a lone claim, a rejected claim, a release by the non-owner, a cancelled request, a hand-over to a pending request, and a same-cycle tie. Together these separate ownership from mere request and show which side wins a tie.

A long pseudo-random sweep follows. It mixes reads, requests, releases and idle cycles on both ports. Its addresses carry noisy upper bits and its data carries noisy upper bits. Every read value is compared with an arithmetic model of the request and ownership rules.

The noisy fields show that only address bits [2:0] and data bit 0 matter. Frequent same-flag collisions exercise hand-over and tie-break against independent flags.

// File: rtl/sem_pkg.sv
// Package: shared types for the semaphore bank.
// Assumes: nothing; pure type definitions.
package sem_pkg;

    // Who currently holds a flag.
    typedef enum logic [1:0] {
        OWN_NONE  = 2'd0,
        OWN_LEFT  = 2'd1,
        OWN_RIGHT = 2'd2
    } owner_e;

endpackage

// File: rtl/sem_port_dec.sv
// Module: sem_port_dec
// Turns one port's write access into per-flag request-set and request-clear strobes.
// Assumes: NUM_FLAGS is a power of two; only index bits of the address and bit 0 of the data matter.
module sem_port_dec #(
    parameter int NUM_FLAGS = 8,
    parameter int ADDR_W    = 15,
    parameter int DATA_W    = 8,
    localparam int IDX_W    = $clog2(NUM_FLAGS)
) (
    input  logic                 sel,
    input  logic                 wr,
    input  logic [ADDR_W-1:0]    addr,
    input  logic [DATA_W-1:0]    wdata,
    output logic [IDX_W-1:0]     idx,
    output logic [NUM_FLAGS-1:0] req_set,
    output logic [NUM_FLAGS-1:0] req_clr
);

    logic unused_bits;

    // Upper address and data bits carry no meaning here (R1, R2).
    assign unused_bits = ^{addr[ADDR_W-1:IDX_W], wdata[DATA_W-1:1]};

    // Flag index is the low address field.
    assign idx = addr[IDX_W-1:0];

    for (genvar g = 0; g < NUM_FLAGS; g++) begin : g_flag
        logic hit;
        // A write strobe lands on this flag only with select and write both high (R10).
        assign hit        = sel && wr && (idx == IDX_W'(g));
        // Data bit 0 low requests, high releases.
        assign req_set[g] = hit && !wdata[0];
        assign req_clr[g] = hit &&  wdata[0];
    end

endmodule

// File: rtl/sem_cell.sv
// Module: sem_cell
// One token flag: a request flip-flop per side plus a sticky ownership register.
// Assumes: set and clear for one side are never both high (guaranteed by the decoder).
module sem_cell
    import sem_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic l_set,
    input  logic l_clr,
    input  logic r_set,
    input  logic r_clr,
    output logic own_l,
    output logic own_r
);

    logic   req_l, req_r;
    logic   req_l_n, req_r_n;
    owner_e owner, owner_n;

    // Next request state: a 0-write raises the request, a 1-write drops it.
    always_comb begin
        req_l_n = l_set ? 1'b1 : (l_clr ? 1'b0 : req_l);
        req_r_n = r_set ? 1'b1 : (r_clr ? 1'b0 : req_r);
    end

    // Ownership: the holder keeps it while requesting; otherwise grant, left first.
    always_comb begin
        if (owner == OWN_LEFT && req_l_n)
            owner_n = OWN_LEFT;
        else if (owner == OWN_RIGHT && req_r_n)
            owner_n = OWN_RIGHT;
        else if (req_l_n)
            owner_n = OWN_LEFT;
        else if (req_r_n)
            owner_n = OWN_RIGHT;
        else
            owner_n = OWN_NONE;
    end

    // State registers with synchronous reset to free, no requests.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            req_l <= 1'b0;
            req_r <= 1'b0;
            owner <= OWN_NONE;
        end else begin
            req_l <= req_l_n;
            req_r <= req_r_n;
            owner <= owner_n;
        end
    end

    assign own_l = (owner == OWN_LEFT);
    assign own_r = (owner == OWN_RIGHT);

    // R3: a lone request on a free flag is granted.
    p_grant_free_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!own_l && !own_r && l_set && !r_set) |=> own_l);

    // R4: the owner keeps the flag until it releases.
    p_keep_owner_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (own_l && !l_clr) |=> own_l);

    // R4: same for the right owner.
    p_keep_owner_right_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (own_r && !r_clr) |=> own_r);

    // R5: a release with the other side requesting hands the flag over.
    p_handoff_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (own_l && l_clr && (req_r || r_set) && !r_clr) |=> own_r);

    // R5: a release with nobody waiting frees the flag.
    p_free_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (own_r && r_clr && !req_l && !l_set) |=> (!own_l && !own_r));

    // R6: same-cycle requests on a free flag go to the left side.
    p_tie_left_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!own_l && !own_r && l_set && r_set) |=> (own_l && req_r));

    // R10: with no strobes, nothing moves.
    p_idle_stable_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!l_set && !l_clr && !r_set && !r_clr) |=> ($stable(own_l) && $stable(own_r)));

endmodule

// File: rtl/sem_readmux.sv
// Module: sem_readmux
// Read-back path for one port: picks the indexed flag and replicates its status.
// Assumes: own holds this side's ownership bits; status is 0 when this side owns.
module sem_readmux #(
    parameter int NUM_FLAGS = 8,
    parameter int DATA_W    = 8,
    localparam int IDX_W    = $clog2(NUM_FLAGS)
) (
    input  logic                 sel,
    input  logic [IDX_W-1:0]     idx,
    input  logic [NUM_FLAGS-1:0] own,
    output logic [DATA_W-1:0]    rdata
);

    logic status;

    // Active-low status of the selected flag as seen from this side.
    assign status = ~own[idx];

    // Replicate across the bus while selected, drive zero otherwise (R7).
    always_comb begin
        rdata = sel ? {DATA_W{status}} : '0;
    end

    // R7: the read bus never shows a mixed pattern.
    always_comb begin
        p_replicated_r7: assert (rdata == '0 || rdata == '1);
    end

endmodule

// File: rtl/sem_bank.sv
// Module: sem_bank (top)
// Bank of token flags shared by a left and a right port, with request/release writes.
// Assumes: both ports run on clk; reads are combinational from the registered state.
module sem_bank #(
    parameter int NUM_FLAGS = 8,
    parameter int ADDR_W    = 15,
    parameter int DATA_W    = 8,
    localparam int IDX_W    = $clog2(NUM_FLAGS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lf_sel,
    input  logic              lf_wr,
    input  logic [ADDR_W-1:0] lf_addr,
    input  logic [DATA_W-1:0] lf_wdata,
    output logic [DATA_W-1:0] lf_rdata,
    input  logic              rt_sel,
    input  logic              rt_wr,
    input  logic [ADDR_W-1:0] rt_addr,
    input  logic [DATA_W-1:0] rt_wdata,
    output logic [DATA_W-1:0] rt_rdata
);

    logic [IDX_W-1:0]     l_idx, r_idx;
    logic [NUM_FLAGS-1:0] l_set, l_clr, r_set, r_clr;
    logic [NUM_FLAGS-1:0] own_l, own_r;

    sem_port_dec #(.NUM_FLAGS(NUM_FLAGS), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dec_l (
        .sel(lf_sel), .wr(lf_wr), .addr(lf_addr), .wdata(lf_wdata),
        .idx(l_idx), .req_set(l_set), .req_clr(l_clr)
    );

    sem_port_dec #(.NUM_FLAGS(NUM_FLAGS), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dec_r (
        .sel(rt_sel), .wr(rt_wr), .addr(rt_addr), .wdata(rt_wdata),
        .idx(r_idx), .req_set(r_set), .req_clr(r_clr)
    );

    for (genvar g = 0; g < NUM_FLAGS; g++) begin : g_cell
        sem_cell u_cell (
            .clk(clk), .rst_n(rst_n),
            .l_set(l_set[g]), .l_clr(l_clr[g]),
            .r_set(r_set[g]), .r_clr(r_clr[g]),
            .own_l(own_l[g]), .own_r(own_r[g])
        );
    end

    sem_readmux #(.NUM_FLAGS(NUM_FLAGS), .DATA_W(DATA_W)) u_rd_l (
        .sel(lf_sel), .idx(l_idx), .own(own_l), .rdata(lf_rdata)
    );

    sem_readmux #(.NUM_FLAGS(NUM_FLAGS), .DATA_W(DATA_W)) u_rd_r (
        .sel(rt_sel), .idx(r_idx), .own(own_r), .rdata(rt_rdata)
    );

    // R4: the two sides never both read a flag as their own.
    p_views_differ_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (lf_sel && rt_sel && l_idx == r_idx) |-> !(lf_rdata == '0 && rt_rdata == '0));

endmodule

// File: tb/sim_sem_bank.sv
module sim_sem_bank;

    localparam int PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        lf_sel = 1'b0, lf_wr = 1'b0;
    logic [14:0] lf_addr = '0;
    logic [7:0]  lf_wdata = '0;
    logic [7:0]  lf_rdata;
    logic        rt_sel = 1'b0, rt_wr = 1'b0;
    logic [14:0] rt_addr = '0;
    logic [7:0]  rt_wdata = '0;
    logic [7:0]  rt_rdata;

    int vectors = 0;
    int errors  = 0;
    bit done    = 1'b0;

    // Reference model: owner 0 free, 1 left, 2 right; request bits per side.
    int own_m [8];
    bit rql [8];
    bit rqr [8];

    always #(PERIOD/2) clk = ~clk;

    sem_bank u0 (
        .clk(clk), .rst_n(rst_n),
        .lf_sel(lf_sel), .lf_wr(lf_wr), .lf_addr(lf_addr), .lf_wdata(lf_wdata), .lf_rdata(lf_rdata),
        .rt_sel(rt_sel), .rt_wr(rt_wr), .rt_addr(rt_addr), .rt_wdata(rt_wdata), .rt_rdata(rt_rdata)
    );

    task automatic check(string tag, string side, logic [7:0] act, logic [7:0] exp);
        vectors++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s port: got %02h expected %02h", tag, side, act, exp);
        end
    endtask

    task automatic model_update();
        for (int f = 0; f < 8; f++) begin
            bit ls, lc, rs, rc, nl, nr;
            ls = lf_sel && lf_wr && lf_addr[2:0] == f && !lf_wdata[0];
            lc = lf_sel && lf_wr && lf_addr[2:0] == f &&  lf_wdata[0];
            rs = rt_sel && rt_wr && rt_addr[2:0] == f && !rt_wdata[0];
            rc = rt_sel && rt_wr && rt_addr[2:0] == f &&  rt_wdata[0];
            nl = ls ? 1'b1 : (lc ? 1'b0 : rql[f]);
            nr = rs ? 1'b1 : (rc ? 1'b0 : rqr[f]);
            if (own_m[f] == 1 && nl)      own_m[f] = 1;
            else if (own_m[f] == 2 && nr) own_m[f] = 2;
            else if (nl)                  own_m[f] = 1;
            else if (nr)                  own_m[f] = 2;
            else                          own_m[f] = 0;
            rql[f] = nl;
            rqr[f] = nr;
        end
    endtask

    // One cycle: drive both ports, check read data against the model, then clock.
    task automatic step(string tag,
                        bit ls, bit lw, logic [14:0] la, logic [7:0] ld,
                        bit rs, bit rw, logic [14:0] ra, logic [7:0] rd);
        @(negedge clk);
        lf_sel = ls; lf_wr = lw; lf_addr = la; lf_wdata = ld;
        rt_sel = rs; rt_wr = rw; rt_addr = ra; rt_wdata = rd;
        #1;
        check(tag, "left",  lf_rdata, !ls ? 8'h00 : (own_m[la[2:0]] == 1 ? 8'h00 : 8'hFF));
        check(tag, "right", rt_rdata, !rs ? 8'h00 : (own_m[ra[2:0]] == 2 ? 8'h00 : 8'hFF));
        @(posedge clk);
        #1;
        if (rst_n) model_update();
    endtask

    // Read one flag on both sides.
    task automatic rd_both(string tag, int f);
        step(tag, 1, 0, 15'(f), 8'h00, 1, 0, 15'(f), 8'h00);
    endtask

    initial begin
        for (int f = 0; f < 8; f++) begin own_m[f] = 0; rql[f] = 0; rqr[f] = 0; end
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R9: reset state, all flags free on both sides.
        for (int f = 0; f < 8; f++) rd_both("R9", f);

        // R1: request with upper address bits set, read back through other aliases.
        step("R1", 1, 1, 15'h7FFA, 8'h00, 0, 0, 15'h0, 8'h00);
        step("R1", 1, 0, 15'h4002, 8'h00, 1, 0, 15'h1232, 8'h00);
        rd_both("R11", 3);

        // R2: upper data bits ignored; 0xFE requests, 0x01 releases.
        step("R2", 0, 0, 15'h0, 8'h00, 1, 1, 15'h0005, 8'hFE);
        rd_both("R2", 5);
        step("R2", 0, 0, 15'h0, 8'h00, 1, 1, 15'h0005, 8'h01);
        rd_both("R2", 5);

        // R3: lone claim of flag 0.
        step("R3", 1, 1, 15'h0000, 8'h00, 0, 0, 15'h0, 8'h00);
        rd_both("R3", 0);

        // R4: non-owner 0-write and 1-write leave the owner's view alone.
        step("R4", 0, 0, 15'h0, 8'h00, 1, 1, 15'h0000, 8'h00);
        rd_both("R4", 0);
        step("R4", 0, 0, 15'h0, 8'h00, 1, 1, 15'h0000, 8'h01);
        rd_both("R4", 0);

        // R8: pending request cancelled, then owner release frees the flag.
        step("R8", 0, 0, 15'h0, 8'h00, 1, 1, 15'h0000, 8'h00);
        step("R8", 0, 0, 15'h0, 8'h00, 1, 1, 15'h0000, 8'h01);
        step("R8", 1, 1, 15'h0000, 8'h01, 0, 0, 15'h0, 8'h00);
        rd_both("R8", 0);

        // R5: hand-over to a pending request, then release to free.
        step("R5", 1, 1, 15'h0000, 8'h00, 0, 0, 15'h0, 8'h00);
        step("R5", 0, 0, 15'h0, 8'h00, 1, 1, 15'h0000, 8'h00);
        step("R5", 1, 1, 15'h0000, 8'h01, 0, 0, 15'h0, 8'h00);
        rd_both("R5", 0);
        step("R5", 0, 0, 15'h0, 8'h00, 1, 1, 15'h0000, 8'h01);
        rd_both("R5", 0);

        // R6: same-cycle claim, left wins, right granted on release.
        step("R6", 1, 1, 15'h0003, 8'h00, 1, 1, 15'h0003, 8'h00);
        rd_both("R6", 3);
        step("R6", 1, 1, 15'h0003, 8'h01, 0, 0, 15'h0, 8'h00);
        rd_both("R6", 3);
        step("R6", 0, 0, 15'h0, 8'h00, 1, 1, 15'h0003, 8'h01);

        // R10: write strobe without select, and select without write, change nothing.
        step("R10", 0, 1, 15'h0006, 8'h00, 0, 1, 15'h0006, 8'h00);
        step("R10", 1, 0, 15'h0006, 8'h00, 1, 0, 15'h0006, 8'h00);
        rd_both("R10", 6);

        // R7: select low reads zero even for a flag another side owns.
        step("R7", 1, 1, 15'h0004, 8'h00, 0, 0, 15'h0004, 8'h00);
        step("R7", 0, 0, 15'h0004, 8'h00, 1, 0, 15'h0004, 8'h00);
        step("R7", 1, 0, 15'h0004, 8'h00, 0, 0, 15'h0004, 8'h00);

        // R11: pseudo-random mixed traffic with noisy upper address and data bits.
        begin
            logic [31:0] lfsr = 32'hACE1_2468;
            for (int n = 0; n < 4000; n++) begin
                logic [31:0] a, b;
                lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
                a = lfsr;
                lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
                b = lfsr;
                step("R11",
                     a[0] | a[1], a[2], {a[14:6], 3'(a[5:3] & {1'b0, a[31], 1'b1})}, a[23:16],
                     b[0] | b[1], b[2], {b[14:6], 3'(b[5:3] & {1'b0, b[31], 1'b1})}, b[23:16]);
            end
        end

        // R9: reset again clears everything.
        @(negedge clk);
        rst_n = 1'b0;
        for (int f = 0; f < 8; f++) begin own_m[f] = 0; rql[f] = 0; rqr[f] = 0; end
        @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        for (int f = 0; f < 8; f++) rd_both("R9", f);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        #(PERIOD * 200000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
            $finish;
        end
    end

endmodule